// File: doc/BRIEF.md
# Parallel Bus Register Front End

This block connects an external microcontroller's byte-wide parallel bus to the register interface inside a chip. The bus uses active-low control: chip select, read strobe and write strobe are each asserted by driving them to 0. The block runs in the bus clock domain and registers every pin before using it. It divides the flat byte address into a register select and a byte index within that register. Each access becomes one single-cycle read or write strobe on the internal side.

For reads, the register file returns its byte one cycle after the read strobe. The front end places that byte on the outgoing data lines. The data pins are split into an input, an output and an output enable, and the pad's tri-state buffer combines them at chip level. The output enable is high only while chip select and the read strobe are both low. This keeps the shared bus free for the microcontroller at all other times.

Top module: `pbus_reg_frontend`

## Requirements
- R1: While `rst_ni` is low, and after it rises until the bus drives an access, `reg_read_o`, `reg_write_o`, `reg_addr_valid_o` and `bus_data_oe_o` are all 0.
- R2: One cycle after a clock edge samples the address pins, `reg_addr_o` equals address bits [20:7] and `reg_idx_o` equals address bits [6:0].
- R3: `reg_addr_valid_o` is 1 exactly in the cycles that follow an edge at which `bus_cen_ni` was sampled low.
- R4: `reg_read_o` is high for one cycle after the first edge that samples `bus_rdn_ni` low with `bus_cen_ni` low, provided the previous edge sampled `bus_rdn_ni` high. A read strobe held low for many cycles produces exactly one pulse.
- R5: `reg_write_o` follows the same rule as R4, using `bus_wrn_ni`. While the pulse is high, `reg_wdata_o` equals the data pins sampled at that same edge.
- R6: A strobe that falls while chip select is high produces no pulse, even if chip select goes low later while the strobe stays low.
- R7: `bus_data_oe_o` is 1 exactly in the cycles after an edge that sampled both `bus_cen_ni` and `bus_rdn_ni` low.
- R8: In the cycle after a read pulse, `bus_data_o` equals the live `reg_rdata_i`. That value is captured at the end of the cycle.
- R9: From the second cycle after a read pulse until the next read pulse, `bus_data_o` stays constant, whatever `reg_rdata_i` does.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk_i | input | 1 | Bus clock |
| rst_ni | input | 1 | Asynchronous reset, active low |
| bus_cen_ni | input | 1 | Chip select, active low |
| bus_rdn_ni | input | 1 | Read strobe, active low |
| bus_wrn_ni | input | 1 | Write strobe, active low |
| bus_addr_i | input | 21 | Flat byte address |
| bus_data_i | input | 8 | Data pins, inbound |
| bus_data_o | output | 8 | Data pins, outbound |
| bus_data_oe_o | output | 1 | Pad output enable |
| reg_addr_o | output | 14 | Register select |
| reg_idx_o | output | 7 | Byte index within register |
| reg_addr_valid_o | output | 1 | Address valid |
| reg_read_o | output | 1 | One-cycle read strobe |
| reg_write_o | output | 1 | One-cycle write strobe |
| reg_wdata_o | output | 8 | Write data |
| reg_rdata_i | input | 8 | Read data, valid one cycle after `reg_read_o` |

## Verification
Wrong edge-detect history would show up at the ports in the same cycle. It would appear as a duplicated or missing `reg_read_o`/`reg_write_o` pulse while a strobe is held low, or as a pulse after a strobe that fell with chip select high. A stale read-return register would show on `bus_data_o` in the cycle after a read pulse, or as drift while the strobe is held. A pipeline off by one stage would misalign the address, valid and output enable with the pins by one cycle. Each of these faults is visible at the first access that exercises it.

// File: rtl/pbus_pkg.sv
package pbus_pkg;
  // sampled control pins, all active low
  typedef struct packed {
    logic cen_n;
    logic rd_n;
    logic wr_n;
  } pbus_ctl_t;

  localparam pbus_ctl_t CTL_IDLE = '{cen_n: 1'b1, rd_n: 1'b1, wr_n: 1'b1};
  localparam int unsigned N_STROBES = 2;  // index 0 read, 1 write
endpackage

// File: rtl/pbus_in_stage.sv
module pbus_in_stage
  import pbus_pkg::*;
#(
  parameter int unsigned ADDR_W = 21,
  parameter int unsigned DATA_W = 8
) (
  input  logic              clk_i,
  input  logic              rst_ni,
  input  pbus_ctl_t         ctl_i,
  input  logic [ADDR_W-1:0] addr_i,
  input  logic [DATA_W-1:0] data_i,
  output pbus_ctl_t         ctl_q_o,
  output pbus_ctl_t         ctl_d1_o,
  output logic [ADDR_W-1:0] addr_q_o,
  output logic [DATA_W-1:0] data_q_o
);
  pbus_ctl_t         ctl_q, ctl_d1;
  logic [ADDR_W-1:0] addr_q;
  logic [DATA_W-1:0] data_q;

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      ctl_q  <= CTL_IDLE;
      ctl_d1 <= CTL_IDLE;
      addr_q <= '0;
      data_q <= '0;
    end else begin
      ctl_q  <= ctl_i;
      ctl_d1 <= ctl_q;
      addr_q <= addr_i;
      data_q <= data_i;
    end
  end

  assign ctl_q_o  = ctl_q;
  assign ctl_d1_o = ctl_d1;
  assign addr_q_o = addr_q;
  assign data_q_o = data_q;
endmodule

// File: rtl/pbus_strobe_edge.sv
module pbus_strobe_edge #(
  parameter int unsigned N = 2
) (
  input  logic [N-1:0] cur_n_i,
  input  logic [N-1:0] prev_n_i,
  input  logic         sel_n_i,
  output logic [N-1:0] pulse_o
);
  // falling edge qualified by chip select in the same sample
  for (genvar g = 0; g < N; g++) begin : g_edge
    assign pulse_o[g] = prev_n_i[g] & ~cur_n_i[g] & ~sel_n_i;
  end
endmodule

// File: rtl/pbus_rd_return.sv
module pbus_rd_return #(
  parameter int unsigned DATA_W = 8
) (
  input  logic              clk_i,
  input  logic              rst_ni,
  input  logic              rd_pulse_i,
  input  logic [DATA_W-1:0] rd_data_i,
  output logic [DATA_W-1:0] data_o
);
  logic              pend_q;
  logic [DATA_W-1:0] hold_q;

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      pend_q <= 1'b0;
      hold_q <= '0;
    end else begin
      pend_q <= rd_pulse_i;
      if (pend_q) hold_q <= rd_data_i;
    end
  end

  // pass-through in the return cycle, held afterwards
  assign data_o = pend_q ? rd_data_i : hold_q;
endmodule

// File: rtl/pbus_reg_frontend.sv
module pbus_reg_frontend
  import pbus_pkg::*;
#(
  parameter int unsigned ADDR_W = 21,
  parameter int unsigned IDX_W  = 7,
  parameter int unsigned DATA_W = 8,
  localparam int unsigned REG_W = ADDR_W - IDX_W
) (
  input  logic              clk_i,
  input  logic              rst_ni,
  input  logic              bus_cen_ni,
  input  logic              bus_rdn_ni,
  input  logic              bus_wrn_ni,
  input  logic [ADDR_W-1:0] bus_addr_i,
  input  logic [DATA_W-1:0] bus_data_i,
  output logic [DATA_W-1:0] bus_data_o,
  output logic              bus_data_oe_o,
  output logic [REG_W-1:0]  reg_addr_o,
  output logic [IDX_W-1:0]  reg_idx_o,
  output logic              reg_addr_valid_o,
  output logic              reg_read_o,
  output logic              reg_write_o,
  output logic [DATA_W-1:0] reg_wdata_o,
  input  logic [DATA_W-1:0] reg_rdata_i
);
  pbus_ctl_t              ctl_in, ctl_q, ctl_d1;
  logic [ADDR_W-1:0]      addr_q;
  logic [N_STROBES-1:0]   strobe_cur, strobe_prev, pulse;

  assign ctl_in = '{cen_n: bus_cen_ni, rd_n: bus_rdn_ni, wr_n: bus_wrn_ni};

  pbus_in_stage #(.ADDR_W(ADDR_W), .DATA_W(DATA_W)) u_in (
    .clk_i   (clk_i),
    .rst_ni  (rst_ni),
    .ctl_i   (ctl_in),
    .addr_i  (bus_addr_i),
    .data_i  (bus_data_i),
    .ctl_q_o (ctl_q),
    .ctl_d1_o(ctl_d1),
    .addr_q_o(addr_q),
    .data_q_o(reg_wdata_o)
  );

  assign strobe_cur  = {ctl_q.wr_n, ctl_q.rd_n};
  assign strobe_prev = {ctl_d1.wr_n, ctl_d1.rd_n};

  pbus_strobe_edge #(.N(N_STROBES)) u_edge (
    .cur_n_i (strobe_cur),
    .prev_n_i(strobe_prev),
    .sel_n_i (ctl_q.cen_n),
    .pulse_o (pulse)
  );

  assign reg_read_o       = pulse[0];
  assign reg_write_o      = pulse[1];
  assign reg_addr_valid_o = ~ctl_q.cen_n;
  assign reg_addr_o       = addr_q[ADDR_W-1:IDX_W];
  assign reg_idx_o        = addr_q[IDX_W-1:0];
  assign bus_data_oe_o    = ~ctl_q.cen_n & ~ctl_q.rd_n;

  pbus_rd_return #(.DATA_W(DATA_W)) u_ret (
    .clk_i     (clk_i),
    .rst_ni    (rst_ni),
    .rd_pulse_i(pulse[0]),
    .rd_data_i (reg_rdata_i),
    .data_o    (bus_data_o)
  );
endmodule

// File: rtl/pbus_reg_frontend_chk.sv
module pbus_reg_frontend_chk #(
  parameter int unsigned DATA_W = 8
) (
  input logic              clk_i,
  input logic              rst_ni,
  input logic              reg_read_o,
  input logic              reg_write_o,
  input logic              reg_addr_valid_o,
  input logic              bus_data_oe_o,
  input logic [DATA_W-1:0] bus_data_o,
  input logic [DATA_W-1:0] reg_rdata_i
);
  AST_RD_SINGLE: assert property (@(posedge clk_i) disable iff (!rst_ni)
    reg_read_o |=> !reg_read_o);  // R4
  AST_WR_SINGLE: assert property (@(posedge clk_i) disable iff (!rst_ni)
    reg_write_o |=> !reg_write_o);  // R5
  AST_RD_QUALIFIED: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (reg_read_o || reg_write_o) |-> reg_addr_valid_o);  // R6
  AST_OE_SELECTED: assert property (@(posedge clk_i) disable iff (!rst_ni)
    bus_data_oe_o |-> reg_addr_valid_o);  // R7
  AST_RETURN_LIVE: assert property (@(posedge clk_i) disable iff (!rst_ni)
    $past(reg_read_o) |-> bus_data_o == reg_rdata_i);  // R8
  AST_HOLD_STABLE: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (!$past(reg_read_o) && !$past(reg_read_o, 2)) |-> $stable(bus_data_o));  // R9
endmodule

bind pbus_reg_frontend pbus_reg_frontend_chk #(.DATA_W(DATA_W)) u_chk (
  .clk_i           (clk_i),
  .rst_ni          (rst_ni),
  .reg_read_o      (reg_read_o),
  .reg_write_o     (reg_write_o),
  .reg_addr_valid_o(reg_addr_valid_o),
  .bus_data_oe_o   (bus_data_oe_o),
  .bus_data_o      (bus_data_o),
  .reg_rdata_i     (reg_rdata_i)
);

// File: tb/pbus_reg_frontend_tb_top.sv
module pbus_reg_frontend_tb_top;
  localparam int AW = 21;
  localparam int IW = 7;
  localparam int DW = 8;

  logic clk = 1'b0;
  logic rst_n = 1'b0;
  logic cen_n = 1'b1, rd_n = 1'b1, wr_n = 1'b1;
  logic [AW-1:0] addr = '0;
  logic [DW-1:0] wdata = '0;
  logic [DW-1:0] rdata = 8'h11;

  logic [DW-1:0]    data_o, wdat_o;
  logic             oe_o, valid_o, rd_o, wr_o;
  logic [AW-IW-1:0] radr_o;
  logic [IW-1:0]    idx_o;

  always #10 clk = ~clk;  // 50 MHz

  pbus_reg_frontend dut_i (
    .clk_i(clk), .rst_ni(rst_n),
    .bus_cen_ni(cen_n), .bus_rdn_ni(rd_n), .bus_wrn_ni(wr_n),
    .bus_addr_i(addr), .bus_data_i(wdata),
    .bus_data_o(data_o), .bus_data_oe_o(oe_o),
    .reg_addr_o(radr_o), .reg_idx_o(idx_o), .reg_addr_valid_o(valid_o),
    .reg_read_o(rd_o), .reg_write_o(wr_o), .reg_wdata_o(wdat_o),
    .reg_rdata_i(rdata)
  );

  // behavioural model: history of pin samples, newest first
  typedef struct {
    bit cen; bit rd; bit wr;
    logic [AW-1:0] a;
    logic [DW-1:0] d;
  } snap_t;

  snap_t hist[$];
  bit pend;
  logic [DW-1:0] hold;
  int vec = 0, bad = 0, rd_seen = 0, wr_seen = 0;
  bit finished = 0;

  function automatic snap_t idle_snap();
    snap_t s;
    s.cen = 1; s.rd = 1; s.wr = 1; s.a = '0; s.d = '0;
    return s;
  endfunction

  function automatic bit exp_rd();
    return hist[1].rd && !hist[0].rd && !hist[0].cen;
  endfunction
  function automatic bit exp_wr();
    return hist[1].wr && !hist[0].wr && !hist[0].cen;
  endfunction

  always @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      hist = {idle_snap(), idle_snap()};
      pend = 0;
      hold = '0;
    end else begin
      snap_t s;
      bit p;
      p = exp_rd();
      if (pend) hold = rdata;
      pend = p;
      s.cen = cen_n; s.rd = rd_n; s.wr = wr_n; s.a = addr; s.d = wdata;
      hist.push_front(s);
      void'(hist.pop_back());
    end
  end

  task automatic chk(input string req, input logic [31:0] act, input logic [31:0] exp);
    vec++;
    if (act !== exp) begin
      bad++;
      $display("FAIL %s: actual %0h expected %0h at %0t", req, act, exp, $time);
    end
  endtask

  task automatic compare_all();
    chk("R4 read pulse", 32'(rd_o), 32'(exp_rd()));
    chk("R5 write pulse", 32'(wr_o), 32'(exp_wr()));
    if (exp_wr()) chk("R5 write data", 32'(wdat_o), 32'(hist[0].d));
    if (!hist[0].cen) begin
      chk("R2 register select", 32'(radr_o), 32'(hist[0].a[AW-1:IW]));
      chk("R2 byte index", 32'(idx_o), 32'(hist[0].a[IW-1:0]));
    end
    chk("R3 address valid", 32'(valid_o), 32'(!hist[0].cen));
    chk("R7 output enable", 32'(oe_o), 32'(!hist[0].cen && !hist[0].rd));
    if (!hist[0].cen && !hist[0].rd)
      chk("R8 read return", 32'(data_o), 32'(pend ? rdata : hold));
    rd_seen += int'(rd_o);
    wr_seen += int'(wr_o);
  endtask

  task automatic step();
    @(negedge clk);
    compare_all();
    rdata = rdata + 8'h3b;
  endtask

  task automatic bus_write(input logic [AW-1:0] a, input logic [DW-1:0] d);
    cen_n = 0; addr = a; wdata = d; step();
    wr_n = 0; step(); step();
    wr_n = 1; step();
    cen_n = 1; step();
  endtask

  task automatic bus_read(input logic [AW-1:0] a, input int n);
    cen_n = 0; addr = a; step();
    rd_n = 0;
    repeat (n) step();
    rd_n = 1; step();
    cen_n = 1; step();
  endtask

  initial begin
    int r0, w0;
    logic [DW-1:0] v1;
    // R1: reset with pins active
    cen_n = 0; rd_n = 0; wr_n = 0;
    repeat (3) begin
      @(negedge clk);
      chk("R1 reset strobes", 32'({rd_o, wr_o}), 32'd0);
      chk("R1 reset valid/oe", 32'({valid_o, oe_o}), 32'd0);
    end
    cen_n = 1; rd_n = 1; wr_n = 1;
    rst_n = 1;
    step(); step();
    chk("R1 idle after reset", 32'({rd_o, wr_o, valid_o, oe_o}), 32'd0);

    // R2 R5: writes at address corners
    w0 = wr_seen;
    bus_write(21'h000000, 8'hA5);
    bus_write(21'h1FFFFF, 8'h5A);
    bus_write(21'h00007F, 8'hFF);
    bus_write(21'h1FFF80, 8'h00);
    bus_write(21'h0ABC42, 8'h3C);
    chk("R5 one pulse per write", 32'(wr_seen - w0), 32'd5);

    // R4 R8: reads, long hold gives a single pulse
    r0 = rd_seen;
    bus_read(21'h012345, 6);
    chk("R4 single pulse on held strobe", 32'(rd_seen - r0), 32'd1);
    bus_read(21'h1F0001, 2);

    // R9: value held while rdata keeps changing
    cen_n = 0; addr = 21'h00A5A5; step();
    rd_n = 0; step(); step(); step();
    v1 = data_o;
    step(); step();
    chk("R9 held read data", 32'(data_o), 32'(v1));
    rd_n = 1; step(); cen_n = 1; step();

    // R4: two strobes within one chip select
    r0 = rd_seen;
    cen_n = 0; step();
    rd_n = 0; step(); step();
    rd_n = 1; step();
    rd_n = 0; step(); step();
    rd_n = 1; step(); cen_n = 1; step();
    chk("R4 back-to-back reads", 32'(rd_seen - r0), 32'd2);

    // R6: strobe falls before chip select
    w0 = wr_seen; r0 = rd_seen;
    wr_n = 0; step(); step();
    cen_n = 0; step(); step(); step();
    chk("R6 write without select", 32'(wr_seen - w0), 32'd0);
    wr_n = 1; cen_n = 1; step();
    rd_n = 0; step(); step();
    cen_n = 0; step(); step();
    chk("R6 read without select", 32'(rd_seen - r0), 32'd0);
    rd_n = 1; cen_n = 1; step(); step();

    // R1: reset in the middle of a read
    cen_n = 0; addr = 21'h001234; step();
    rd_n = 0; step();
    rst_n = 0;
    #1;
    chk("R1 mid-run reset", 32'({rd_o, wr_o, valid_o, oe_o}), 32'd0);
    @(negedge clk);
    cen_n = 1; rd_n = 1;
    rst_n = 1;
    step(); step();
    bus_read(21'h0FEDCB, 3);

    finished = 1;
    $display("== %0d vectors applied, %0d miscompares ==", vec, bad);
    $finish;
  end

  initial begin
    repeat (20000) @(posedge clk);
    if (!finished) begin
      bad++;
      $display("FAIL watchdog: actual timeout expected completion");
      $display("== %0d vectors applied, %0d miscompares ==", vec, bad);
      $finish;
    end
  end
endmodule